// File: doc/BRIEF.md
# Dual Wiper Register Bank with Stored Presets

This block is the register core behind a two-channel, 64-step digital potentiometer. Each channel owns a 6-bit live wiper code that picks exactly one tap (0 to 63), plus four 6-bit preset slots that stand in for non-volatile storage. A serial front end, not part of this block, assembles an instruction and then pulses a one-cycle commit strobe together with a 4-bit operation code, a channel number and a data byte. The bank acts on that strobe only. It can read or load the live code, read or load a preset, move a value between a channel's live code and one of its own presets, and step the live code by one position in either direction.

The preset slots are not cleared by reset. They keep their contents across reset, and a parameter gives their initial contents. Reset copies preset 0 of each channel into that channel's live code. This models the recall of the saved wiper setting at power-up. Storing into a preset holds the bank busy for a programmable number of cycles, which models the non-volatile write time. A write-enable input from the front end can cancel any operation that would change state, while reads stay available.

Top module: `wiper_bank`

## Requirements
- R1: While `rst` is high on a clock edge, each channel's live code takes the current value of its preset 0, and `busy` and `rd_valid` go low. `rd_data` clears to zero.
- R2: Op 0x1, when it takes effect, loads `cmd_data[5:0]` into the live code of channel `cmd_chan` on the commit edge. The other channel is unchanged.
- R3: Op 0x0 returns the selected live code and op 0x2 returns preset `cmd_data[7:6]` of the selected channel. The value appears in `rd_data[5:0]`, with `rd_data[7:6]` zero, and `rd_valid` is high for the single cycle after the commit edge.
- R4: Op 0x3, when it takes effect, stores `cmd_data[5:0]` into preset `cmd_data[7:6]` of the selected channel.
- R5: Op 0x4 copies preset `cmd_data[7:6]` into the selected live code. Op 0x5 copies the selected live code into that preset.
- R6: Op 0x6 raises the selected live code by one and op 0x7 lowers it by one. The code stops at 63 going up and at 0 going down, and it never wraps.
- R7: With `wr_allow` low, ops 0x1, 0x3, 0x4, 0x5, 0x6 and 0x7 change no live code and no preset, and they do not raise `busy`. Reads still return data.
- R8: An op 0x3 or 0x5 that takes effect drives `busy` high for exactly BUSY_CYCLES cycles, starting in the cycle after the commit. Any commit that arrives while `busy` is high is dropped: no state change and no `rd_valid`.
- R9: Op codes 0x8 to 0xF, and any cycle with `cmd_commit` low, leave the live codes, the presets and `busy` alone and produce no `rd_valid`.
- R10: Preset contents start from the PRESET_INIT parameter and survive a reset. A value stored before a reset into preset 0 becomes the live code after that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up recall) |
| cmd_commit | input | 1 | One-cycle strobe: execute the presented instruction |
| cmd_op | input | 4 | Operation code |
| cmd_chan | input | 1 | Channel number |
| cmd_data | input | 8 | Data byte: [5:0] value, [7:6] preset slot |
| wr_allow | input | 1 | High lets state-changing operations take effect |
| wiper_codes | output | 12 | Live codes, channel 0 in [5:0], channel 1 in [11:6] |
| busy | output | 1 | Preset store in progress; commits are dropped |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 8 | Read result, zero-extended 6-bit value |

## Verification
A wrong live code appears on `wiper_codes` in the very cycle after the commit that produced it. Every edge is compared against a behavioural model, so a bad step, copy or saturation shows up within one cycle. A corrupted preset is hidden until it is read back, copied to the live code, or recalled by reset. The bench therefore reads presets back, copies them to the live codes, and recalls preset 0 with a reset to bring that state out to the ports. A busy counter that is off by one appears either as `busy` falling one cycle early or late, or as a commit at the window edge being taken or dropped against the model.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  typedef enum logic [3:0] {
    OP_RD_LIVE  = 4'h0,
    OP_WR_LIVE  = 4'h1,
    OP_RD_PRE   = 4'h2,
    OP_WR_PRE   = 4'h3,
    OP_PRE2LIVE = 4'h4,
    OP_LIVE2PRE = 4'h5,
    OP_STEP_UP  = 4'h6,
    OP_STEP_DN  = 4'h7
  } wb_op_e;
endpackage

// File: rtl/wbank_presets.sv
module wbank_presets #(
  parameter int CODE_W = 6,
  parameter int PRESETS = 4,
  parameter logic [PRESETS*CODE_W-1:0] INIT = '0,
  localparam int IDX_W = (PRESETS > 1) ? $clog2(PRESETS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [CODE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [CODE_W-1:0] rdata,
  output logic [CODE_W-1:0] slot0
);
  // Storage is not reset: it models non-volatile cells.
  logic [CODE_W-1:0] store [PRESETS];

  initial begin
    for (int k = 0; k < PRESETS; k++) store[k] = INIT[k*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  assign rdata = store[ridx];
  assign slot0 = store[0];
endmodule

// File: rtl/wbank_live.sv
module wbank_live #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] recall_val,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_val,
  input  logic              up_en,
  input  logic              dn_en,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)              code <= recall_val;
    else if (load_en)     code <= load_val;
    else if (up_en)       code <= (code == TOP) ? code : code + 1'b1;
    else if (dn_en)       code <= (code == '0) ? code : code - 1'b1;
  end

  assert_sat_top_R6: assert property (@(posedge clk) disable iff (rst)
    (up_en && !load_en && code == TOP) |=> code == TOP);
  assert_sat_bottom_R6: assert property (@(posedge clk) disable iff (rst)
    (dn_en && !load_en && !up_en && code == '0) |=> code == '0);
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> code == $past(load_val));
  assert_recall_R1: assert property (@(posedge clk)
    rst |=> code == $past(recall_val));
endmodule

// File: rtl/wbank_busy.sv
module wbank_busy #(
  parameter int BUSY_CYCLES = 20,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wbank_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int CODE_W = 6,
  parameter int PRESETS = 4,
  parameter int DATA_W = 8,
  parameter int BUSY_CYCLES = 20,
  parameter logic [CHANNELS*PRESETS*CODE_W-1:0] PRESET_INIT = '0,
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int IDX_W = (PRESETS > 1) ? $clog2(PRESETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_commit,
  input  logic [3:0]                 cmd_op,
  input  logic [CH_W-1:0]            cmd_chan,
  input  logic [DATA_W-1:0]          cmd_data,
  input  logic                       wr_allow,
  output logic [CHANNELS*CODE_W-1:0] wiper_codes,
  output logic                       busy,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int SLICE = PRESETS * CODE_W;

  logic              accept, modify, chan_ok, store_start;
  logic [IDX_W-1:0]  slot;
  logic [CODE_W-1:0] value, rd_pick;
  logic [CODE_W-1:0] live_q [CHANNELS];
  logic [CODE_W-1:0] pre_rd [CHANNELS];
  logic [CODE_W-1:0] pre_s0 [CHANNELS];

  assign chan_ok = (int'(cmd_chan) < CHANNELS);
  assign accept  = cmd_commit && !busy && chan_ok;
  assign modify  = accept && wr_allow;
  assign slot    = cmd_data[DATA_W-1 -: IDX_W];
  assign value   = cmd_data[CODE_W-1:0];
  assign store_start = modify && (cmd_op == OP_WR_PRE || cmd_op == OP_LIVE2PRE);

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic sel, ld, up, dn, we;
    assign sel = (cmd_chan == CH_W'(c));
    assign ld  = modify && sel && (cmd_op == OP_WR_LIVE || cmd_op == OP_PRE2LIVE);
    assign up  = modify && sel && (cmd_op == OP_STEP_UP);
    assign dn  = modify && sel && (cmd_op == OP_STEP_DN);
    assign we  = modify && sel && (cmd_op == OP_WR_PRE || cmd_op == OP_LIVE2PRE);

    wbank_presets #(.CODE_W(CODE_W), .PRESETS(PRESETS),
                    .INIT(PRESET_INIT[c*SLICE +: SLICE])) u_pre (
      .clk   (clk),
      .we    (we),
      .widx  (slot),
      .wdata ((cmd_op == OP_WR_PRE) ? value : live_q[c]),
      .ridx  (slot),
      .rdata (pre_rd[c]),
      .slot0 (pre_s0[c])
    );

    wbank_live #(.CODE_W(CODE_W)) u_live (
      .clk        (clk),
      .rst        (rst),
      .recall_val (pre_s0[c]),
      .load_en    (ld),
      .load_val   ((cmd_op == OP_WR_LIVE) ? value : pre_rd[c]),
      .up_en      (up),
      .dn_en      (dn),
      .code       (live_q[c])
    );

    assign wiper_codes[c*CODE_W +: CODE_W] = live_q[c];
  end

  wbank_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (store_start),
    .busy  (busy)
  );

  always_comb begin
    rd_pick = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (cmd_chan == CH_W'(c))
        rd_pick = (cmd_op == OP_RD_PRE) ? pre_rd[c] : live_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && (cmd_op == OP_RD_LIVE || cmd_op == OP_RD_PRE);
      if (accept && (cmd_op == OP_RD_LIVE || cmd_op == OP_RD_PRE))
        rd_data <= DATA_W'(rd_pick);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !rd_valid));
  assert_read_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_data[DATA_W-1:CODE_W] == '0);
  assert_protect_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && !wr_allow) |=> $stable(wiper_codes));
  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && busy) |=> (!rd_valid && $stable(wiper_codes)));
  assert_bad_op_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_commit && cmd_op[3]) |=> (!rd_valid && $stable(wiper_codes)));
endmodule

// File: tb/sim_wiper_bank.sv
module sim_wiper_bank;
  localparam int BC = 6;
  localparam logic [47:0] INIT = {6'd53, 6'd52, 6'd51, 6'd50, 6'd13, 6'd12, 6'd11, 6'd10};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        commit = 1'b0;
  logic [3:0]  op = '0;
  logic        ch = 1'b0;
  logic [7:0]  data = '0;
  logic        allow = 1'b1;
  logic [11:0] codes;
  logic        busy, rdv;
  logic [7:0]  rdd;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  int m_live [2];
  int m_pre [2][4];
  int m_busy = 0;
  bit m_rdv = 0;
  int m_rdd = 0;

  always #2 clk = ~clk;

  wiper_bank #(.BUSY_CYCLES(BC), .PRESET_INIT(INIT)) u0 (
    .clk(clk), .rst(rst), .cmd_commit(commit), .cmd_op(op), .cmd_chan(ch),
    .cmd_data(data), .wr_allow(allow), .wiper_codes(codes), .busy(busy),
    .rd_valid(rdv), .rd_data(rdd)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int c, i, v, nb;
    if (rst) begin
      for (int k = 0; k < 2; k++) m_live[k] = m_pre[k][0];
      m_busy = 0; m_rdv = 0; m_rdd = 0;
      return;
    end
    c = ch; i = data[7:6]; v = data[5:0];
    nb = (m_busy > 0) ? m_busy - 1 : 0;
    m_rdv = 0;
    if (commit && m_busy == 0) begin
      if (op == 0) begin m_rdv = 1; m_rdd = m_live[c]; end
      if (op == 2) begin m_rdv = 1; m_rdd = m_pre[c][i]; end
      if (allow) begin
        case (op)
          4'h1: m_live[c] = v;
          4'h3: begin m_pre[c][i] = v; nb = BC; end
          4'h4: m_live[c] = m_pre[c][i];
          4'h5: begin m_pre[c][i] = m_live[c]; nb = BC; end
          4'h6: if (m_live[c] < 63) m_live[c]++;
          4'h7: if (m_live[c] > 0) m_live[c]--;
          default: ;
        endcase
      end
    end
    m_busy = nb;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(int'(codes[5:0]) == m_live[0], tag, "wiper0", codes[5:0], m_live[0]);
    chk(int'(codes[11:6]) == m_live[1], tag, "wiper1", codes[11:6], m_live[1]);
    chk(busy == (m_busy != 0), tag, "busy", busy, m_busy != 0);
    chk(rdv == m_rdv, tag, "rd_valid", rdv, m_rdv);
    chk(int'(rdd) == m_rdd, tag, "rd_data", rdd, m_rdd);
  endtask

  task automatic cmd(input int o, input int c, input int d);
    commit = 1'b1; op = 4'(o); ch = c[0]; data = 8'(d);
    tick();
    commit = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(2); rst = 1'b0;
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) m_pre[k/4][k%4] = INIT[k*6 +: 6];
    m_live[0] = 0; m_live[1] = 0;
    @(negedge clk);
    tag = "R1"; do_reset();
    chk(codes[5:0] == 6'd10 && codes[11:6] == 6'd50, "R1", "recall pair", codes, {6'd50, 6'd10});
    chk(!busy && !rdv, "R1", "idle flags", {busy, rdv}, 0);

    tag = "R3"; cmd(0, 0, 0); cmd(0, 1, 0); cmd(2, 1, 8'h80); idle(1);
    tag = "R2"; cmd(1, 0, 33); cmd(1, 1, 7); cmd(1, 0, 8'hC5); idle(1);
    chk(codes[5:0] == 6'd5, "R2", "upper bits not value", codes[5:0], 5);

    tag = "R4"; cmd(3, 0, 8'h40 | 21);
    tag = "R8"; cmd(1, 1, 60); cmd(0, 0, 0); idle(BC - 3);
    chk(busy == 1'b1, "R8", "busy last cycle", busy, 1);
    cmd(0, 1, 0); tick();
    chk(busy == 1'b0, "R8", "busy end", busy, 0);
    tag = "R4"; cmd(2, 0, 8'h40); idle(1);

    tag = "R5"; cmd(4, 0, 8'h40); cmd(5, 1, 8'hC0); idle(BC); cmd(2, 1, 8'hC0); idle(1);

    tag = "R6"; cmd(1, 0, 62); cmd(6, 0, 0); cmd(6, 0, 0); cmd(6, 0, 0);
    chk(codes[5:0] == 6'd63, "R6", "saturate top", codes[5:0], 63);
    cmd(1, 1, 1); cmd(7, 1, 0); cmd(7, 1, 0); cmd(7, 1, 0);
    chk(codes[11:6] == 6'd0, "R6", "saturate bottom", codes[11:6], 0);

    tag = "R7"; allow = 1'b0;
    cmd(1, 0, 3); cmd(3, 1, 8'h40 | 9); cmd(4, 0, 0); cmd(5, 0, 8'h80); cmd(6, 1, 0); cmd(7, 0, 0);
    chk(!busy, "R7", "no busy", busy, 0);
    cmd(2, 1, 8'h40); cmd(0, 0, 0); idle(1);
    allow = 1'b1;

    tag = "R9"; for (int o = 8; o < 16; o++) cmd(o, o % 2, 8'hFF);
    commit = 1'b0; op = 4'h1; data = 8'd17; idle(2);

    tag = "R10"; cmd(3, 0, 44); idle(BC); cmd(1, 1, 27); cmd(5, 1, 0); idle(BC);
    cmd(1, 0, 1); cmd(1, 1, 2); do_reset();
    chk(codes[5:0] == 6'd44 && codes[11:6] == 6'd27, "R10", "recall stored", codes, {6'd27, 6'd44});

    tag = "R8";
    for (int n = 0; n < 400; n++) begin
      commit = ($urandom_range(0, 3) != 0);
      op = 4'($urandom_range(0, 9));
      ch = 1'($urandom_range(0, 1));
      data = 8'($urandom_range(0, 255));
      allow = ($urandom_range(0, 7) != 0);
      tick();
    end
    commit = 1'b0; allow = 1'b1; idle(BC + 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule